// File: doc/BRIEF.md
# Ping-Pong Field-Aware Block Transfer Controller

This block moves video lines from a two-half staging buffer into a frame memory. An upstream writer fills one half of the staging buffer while the other half is being drained. Each time a half is full, the writer pulses `trigger`. The controller then copies that whole half in one burst. It reads the source through a synchronous read port with one cycle of latency and writes each returned word to the destination port.

The next set of addresses comes from counters, not from chained parameter sets. Every completed transfer flips the source between the two halves. The destination start address steps forward by one transfer size for each transfer inside a field. After a fixed number of transfers, it jumps to the start address of the other field (odd or even), so the two interlaced fields land in separate regions of the frame memory.

Completion is reported by a one-cycle interrupt pulse and a completion code that stays readable. A trigger that arrives while a burst is running is remembered and served after the burst ends. A further trigger beyond that one is dropped and raises a sticky overrun flag.

Top module: `xfer_pingpong`

## Requirements
- R1: After reset the block is idle: `busy`, `srcRdEn`, `dstWrEn`, `doneIrq`, `overrun` and `fieldSel` are 0, and `doneCode` is 4'b0000.
- R2: When a trigger is sampled in an idle cycle, `srcRdEn` is high for exactly WORDS consecutive cycles starting with the next cycle. `srcAddr` runs from the current half's base upward by 1 per cycle.
- R3: Each read is followed one cycle later by a write. In that write, `dstWrData` equals the word returned on `srcRdData`, and `dstAddr` is the transfer's destination start plus the word's index within the transfer.
- R4: The first transfer reads from half 0 (base SRC_HALF0). Each later transfer reads from the other half than the one before it.
- R5: Inside a field, each transfer's destination start is the previous transfer's start plus WORDS.
- R6: The first XFERS_PER_FIELD transfers target the odd field at ODD_BASE. The next XFERS_PER_FIELD transfers target the even field at EVEN_BASE, and the fields keep alternating. `fieldSel` reads 0 while the next transfer targets the odd field and 1 while it targets the even field.
- R7: `doneIrq` is high for exactly one cycle. That cycle is the one right after the last destination write of a transfer, and `busy` falls in the same cycle.
- R8: `doneCode` reads 4'b0111 from the first completion pulse on and holds it between completions.
- R9: A single trigger during a busy transfer is latched. The next transfer begins (`srcRdEn` high) in the cycle after the completion pulse, with no new trigger needed.
- R10: A trigger that arrives while busy with one trigger already latched is dropped and sets `overrun`. `overrun` stays 1 until reset, and only the latched transfer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| trigger | input | 1 | Half-buffer full request, sampled each cycle |
| srcRdEn | output | 1 | Source read strobe |
| srcAddr | output | AW | Source read address |
| srcRdData | input | DW | Source data, valid one cycle after `srcRdEn` |
| dstWrEn | output | 1 | Destination write strobe |
| dstAddr | output | AW | Destination write address |
| dstWrData | output | DW | Destination write data |
| doneIrq | output | 1 | One-cycle completion interrupt |
| doneCode | output | 4 | Completion code, 4'b0111 after first completion |
| busy | output | 1 | Transfer in progress |
| overrun | output | 1 | Sticky flag: a trigger was dropped |
| fieldSel | output | 1 | Field targeted by the next transfer (0 odd, 1 even) |

## Verification
The assertions assume that the source port returns data exactly one cycle after each read strobe. They also assume that `trigger` is a synchronous level sampled at the rising edge, so two high cycles count as two requests. The bench's source model is a registered read that computes each word from its address. Triggers are driven as single-cycle pulses at the falling edge. A run of overlapping requests is built on purpose in the overrun scenario: one pulse starts a transfer, and two more pulses arrive while it is busy.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } xferState_e;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic startXfer;   // transfer accepted this cycle
    logic issueRead;   // one source read this cycle
    logic endXfer;     // last write in flight, update addresses
  } xferStrobe_t;

  localparam logic [3:0] DONE_CODE = 4'b0111;

endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int WORDS = 4000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigger,
  output xferStrobe_t strobe,
  output logic        busy,
  output logic        doneIrq,
  output logic [3:0]  doneCode,
  output logic        overrun
);

  localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CW-1:0] LAST_WORD = CW'(WORDS - 1);

  xferState_e state, stateNext;
  logic [CW-1:0] wordCnt;
  logic pending;

  assign busy = (state != ST_IDLE);

  always_comb begin
    strobe.startXfer = (state == ST_IDLE) && (trigger || pending);
    strobe.issueRead = (state == ST_RUN);
    strobe.endXfer   = (state == ST_DRAIN);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (strobe.startXfer) stateNext = ST_RUN;
      ST_RUN:   if (wordCnt == LAST_WORD) stateNext = ST_DRAIN;
      ST_DRAIN: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wordCnt  <= '0;
      pending  <= 1'b0;
      overrun  <= 1'b0;
      doneIrq  <= 1'b0;
      doneCode <= 4'b0000;
    end else begin
      state   <= stateNext;
      doneIrq <= strobe.endXfer;
      if (strobe.endXfer) doneCode <= DONE_CODE;

      if (strobe.startXfer) wordCnt <= '0;
      else if (strobe.issueRead) wordCnt <= wordCnt + 1'b1;

      if (busy) begin
        if (trigger) begin
          if (pending) overrun <= 1'b1;
          else pending <= 1'b1;
        end
      end else if (strobe.startXfer) begin
        // one request consumed; a simultaneous second one stays latched
        pending <= pending && trigger;
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

  // R7
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneIrq);

  // R10
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && trigger && pending) |=> overrun);

  // R10
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R9
  pending_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneIrq && pending) |=> busy);

endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
#(
  parameter int            WORDS           = 4000,
  parameter int            XFERS_PER_FIELD = 12,
  parameter int            AW              = 20,
  parameter int            DW              = 32,
  parameter logic [AW-1:0] SRC_HALF0       = '0,
  parameter logic [AW-1:0] SRC_HALF1       = AW'(4096),
  parameter logic [AW-1:0] ODD_BASE        = AW'(65536),
  parameter logic [AW-1:0] EVEN_BASE       = AW'(131072)
) (
  input  logic          clk,
  input  logic          rstN,
  input  xferStrobe_t   strobe,
  input  logic [DW-1:0] srcRdData,
  output logic          srcRdEn,
  output logic [AW-1:0] srcAddr,
  output logic          dstWrEn,
  output logic [AW-1:0] dstAddr,
  output logic [DW-1:0] dstWrData,
  output logic          fieldSel
);

  localparam int FCW = (XFERS_PER_FIELD > 1) ? $clog2(XFERS_PER_FIELD) : 1;
  localparam logic [FCW-1:0] LAST_IN_FIELD = FCW'(XFERS_PER_FIELD - 1);
  localparam logic [AW-1:0]  STEP = AW'(WORDS);

  logic          srcHalf;
  logic [FCW-1:0] fieldCnt;
  logic [AW-1:0] dstStart;
  logic [AW-1:0] rdOfs;
  logic          wrValidQ;
  logic [AW-1:0] wrAddrQ;
  logic [AW-1:0] srcBase;

  assign srcBase   = srcHalf ? SRC_HALF1 : SRC_HALF0;
  assign srcRdEn   = strobe.issueRead;
  assign srcAddr   = srcBase + rdOfs;
  assign dstWrEn   = wrValidQ;
  assign dstAddr   = wrAddrQ;
  assign dstWrData = srcRdData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcHalf  <= 1'b0;
      fieldSel <= 1'b0;
      fieldCnt <= '0;
      dstStart <= ODD_BASE;
      rdOfs    <= '0;
      wrValidQ <= 1'b0;
      wrAddrQ  <= '0;
    end else begin
      wrValidQ <= strobe.issueRead;
      wrAddrQ  <= dstStart + rdOfs;

      if (strobe.startXfer) rdOfs <= '0;
      else if (strobe.issueRead) rdOfs <= rdOfs + 1'b1;

      if (strobe.endXfer) begin
        srcHalf <= ~srcHalf;
        if (fieldCnt == LAST_IN_FIELD) begin
          fieldCnt <= '0;
          fieldSel <= ~fieldSel;
          dstStart <= fieldSel ? ODD_BASE : EVEN_BASE;
        end else begin
          fieldCnt <= fieldCnt + 1'b1;
          dstStart <= dstStart + STEP;
        end
      end
    end
  end

  // R3
  wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    dstWrEn |-> $past(srcRdEn));

  // R3
  wr_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dstWrEn && $past(dstWrEn)) |-> (dstAddr == $past(dstAddr) + 1'b1));

  // R4
  half_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.endXfer) |-> (srcHalf != $past(srcHalf)));

  // R6
  field_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    fieldCnt <= LAST_IN_FIELD);

endmodule

// File: rtl/xfer_pingpong.sv
module xfer_pingpong
  import xfer_pkg::*;
#(
  parameter int            WORDS           = 4000,
  parameter int            XFERS_PER_FIELD = 12,
  parameter int            AW              = 20,
  parameter int            DW              = 32,
  parameter logic [AW-1:0] SRC_HALF0       = '0,
  parameter logic [AW-1:0] SRC_HALF1       = AW'(4096),
  parameter logic [AW-1:0] ODD_BASE        = AW'(65536),
  parameter logic [AW-1:0] EVEN_BASE       = AW'(131072)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          trigger,
  output logic          srcRdEn,
  output logic [AW-1:0] srcAddr,
  input  logic [DW-1:0] srcRdData,
  output logic          dstWrEn,
  output logic [AW-1:0] dstAddr,
  output logic [DW-1:0] dstWrData,
  output logic          doneIrq,
  output logic [3:0]    doneCode,
  output logic          busy,
  output logic          overrun,
  output logic          fieldSel
);

  xferStrobe_t strobe;

  xfer_ctrl #(.WORDS(WORDS)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .trigger  (trigger),
    .strobe   (strobe),
    .busy     (busy),
    .doneIrq  (doneIrq),
    .doneCode (doneCode),
    .overrun  (overrun)
  );

  xfer_datapath #(
    .WORDS           (WORDS),
    .XFERS_PER_FIELD (XFERS_PER_FIELD),
    .AW              (AW),
    .DW              (DW),
    .SRC_HALF0       (SRC_HALF0),
    .SRC_HALF1       (SRC_HALF1),
    .ODD_BASE        (ODD_BASE),
    .EVEN_BASE       (EVEN_BASE)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .srcRdData (srcRdData),
    .srcRdEn   (srcRdEn),
    .srcAddr   (srcAddr),
    .dstWrEn   (dstWrEn),
    .dstAddr   (dstAddr),
    .dstWrData (dstWrData),
    .fieldSel  (fieldSel)
  );

endmodule

// File: tb/sim_xfer_pingpong.sv
module sim_xfer_pingpong;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 6;
  localparam int XF = 12;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [AW-1:0] H0   = 16'h0000;
  localparam logic [AW-1:0] H1   = 16'h0100;
  localparam logic [AW-1:0] ODDB = 16'h4000;
  localparam logic [AW-1:0] EVNB = 16'h8000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigger = 1'b0;
  logic srcRdEn, dstWrEn, doneIrq, busy, overrun, fieldSel;
  logic [AW-1:0] srcAddr, dstAddr;
  logic [DW-1:0] srcRdData = '0;
  logic [DW-1:0] dstWrData;
  logic [3:0] doneCode;

  int checks = 0;
  int errors = 0;
  int cycle = 0;
  int xferIdx = 0;
  int rdIdx = 0;
  int wrIdx = 0;
  int lastWrCycle = -10;
  int prevDone = 0;
  logic [AW-1:0] firstDst [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_pingpong #(
    .WORDS(W), .XFERS_PER_FIELD(XF), .AW(AW), .DW(DW),
    .SRC_HALF0(H0), .SRC_HALF1(H1), .ODD_BASE(ODDB), .EVEN_BASE(EVNB)
  ) u0 (
    .clk(clk), .rstN(rstN), .trigger(trigger),
    .srcRdEn(srcRdEn), .srcAddr(srcAddr), .srcRdData(srcRdData),
    .dstWrEn(dstWrEn), .dstAddr(dstAddr), .dstWrData(dstWrData),
    .doneIrq(doneIrq), .doneCode(doneCode), .busy(busy),
    .overrun(overrun), .fieldSel(fieldSel)
  );

  function automatic logic [DW-1:0] srcWord(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3};
  endfunction

  function automatic logic [AW-1:0] expSrc(input int k);
    return (k % 2 == 1) ? H1 : H0;
  endfunction

  function automatic logic [AW-1:0] expDst(input int k);
    logic [AW-1:0] b;
    b = (((k / XF) % 2) == 1) ? EVNB : ODDB;
    return b + AW'((k % XF) * W);
  endfunction

  // source memory model: registered read, one cycle latency
  always @(posedge clk) if (srcRdEn) srcRdData <= srcWord(srcAddr);

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  // stream monitor: R2 R3 R4 R5 R6 R7 R8
  always @(negedge clk) begin
    cycle++;
    if (rstN) begin
      if (srcRdEn) begin
        chk(rdIdx < W, "R2 read count", rdIdx, W - 1);
        chk(srcAddr == expSrc(xferIdx) + AW'(rdIdx), "R2/R4 srcAddr",
            srcAddr, expSrc(xferIdx) + AW'(rdIdx));
        rdIdx++;
      end
      if (dstWrEn) begin
        if (wrIdx == 0 && xferIdx < 64) firstDst[xferIdx] = dstAddr;
        chk(dstAddr == expDst(xferIdx) + AW'(wrIdx), "R3/R5/R6 dstAddr",
            dstAddr, expDst(xferIdx) + AW'(wrIdx));
        chk(dstWrData == srcWord(expSrc(xferIdx) + AW'(wrIdx)), "R3 dstWrData",
            dstWrData, srcWord(expSrc(xferIdx) + AW'(wrIdx)));
        wrIdx++;
        lastWrCycle = cycle;
      end
      if (doneIrq) begin
        chk(prevDone == 0, "R7 single pulse", 1, 0);
        chk(lastWrCycle == cycle - 1, "R7 pulse after last write", lastWrCycle, cycle - 1);
        chk(busy == 1'b0, "R7 busy low at pulse", busy, 0);
        chk(rdIdx == W && wrIdx == W, "R2 words per transfer", wrIdx, W);
        chk(doneCode == 4'b0111, "R8 doneCode", doneCode, 4'b0111);
        xferIdx++;
        rdIdx = 0;
        wrIdx = 0;
      end
      prevDone = doneIrq ? 1 : 0;
    end
  end

  task automatic pulseTrigger();
    @(negedge clk);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
  endtask

  task automatic waitDone(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (doneIrq) begin
        seen = 1'b1;
        break;
      end
    end
    if (!seen) chk(1'b0, "watch doneIrq timeout", 0, 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(srcRdEn == 0 && dstWrEn == 0, "R1 strobes", {srcRdEn, dstWrEn}, 0);
    chk(doneIrq == 0, "R1 doneIrq", doneIrq, 0);
    chk(overrun == 0, "R1 overrun", overrun, 0);
    chk(fieldSel == 0, "R1 fieldSel", fieldSel, 0);
    chk(doneCode == 4'b0000, "R1 doneCode", doneCode, 0);
  endtask

  task automatic testSingle();
    bit seen;
    @(negedge clk);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    chk(srcRdEn == 1'b1, "R2 read starts next cycle", srcRdEn, 1);
    chk(srcAddr == H0, "R4 first half", srcAddr, H0);
    waitDone(seen);
    @(negedge clk);
    chk(doneIrq == 0, "R7 pulse one cycle", doneIrq, 0);
    repeat (5) @(negedge clk);
    chk(doneCode == 4'b0111, "R8 code held", doneCode, 4'b0111);
    chk(xferIdx == 1, "R2 one transfer per trigger", xferIdx, 1);
  endtask

  task automatic testFields();
    bit seen;
    for (int i = 1; i < 25; i++) begin
      pulseTrigger();
      waitDone(seen);
      @(negedge clk);
      if (i == 11) chk(fieldSel == 1'b1, "R6 fieldSel even after field", fieldSel, 1);
      if (i == 10) chk(fieldSel == 1'b0, "R6 fieldSel odd inside field", fieldSel, 0);
    end
    repeat (2) @(negedge clk);
    chk(firstDst[1] == ODDB + AW'(W), "R5 step within field", firstDst[1], ODDB + AW'(W));
    chk(firstDst[11] == ODDB + AW'(11 * W), "R5 last odd", firstDst[11], ODDB + AW'(11 * W));
    chk(firstDst[12] == EVNB, "R6 switch to even", firstDst[12], EVNB);
    chk(firstDst[23] == EVNB + AW'(11 * W), "R5 last even", firstDst[23], EVNB + AW'(11 * W));
    chk(firstDst[24] == ODDB, "R6 back to odd", firstDst[24], ODDB);
    chk(fieldSel == 1'b0, "R6 fieldSel odd again", fieldSel, 0);
  endtask

  task automatic testPending();
    bit seen;
    int base;
    base = xferIdx;
    pulseTrigger();
    @(negedge clk);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    waitDone(seen);
    @(negedge clk);
    chk(srcRdEn == 1'b1, "R9 latched start after pulse", srcRdEn, 1);
    waitDone(seen);
    repeat (10) @(negedge clk);
    chk(xferIdx == base + 2, "R9 two transfers", xferIdx, base + 2);
    chk(overrun == 1'b0, "R9 no overrun", overrun, 0);
    chk(busy == 1'b0, "R9 idle after", busy, 0);
  endtask

  task automatic testOverrun();
    bit seen;
    int base;
    base = xferIdx;
    pulseTrigger();
    @(negedge clk);
    trigger = 1'b1;
    @(negedge clk);
    @(negedge clk);
    trigger = 1'b0;
    chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
    waitDone(seen);
    waitDone(seen);
    repeat (20) @(negedge clk);
    chk(xferIdx == base + 2, "R10 extra trigger dropped", xferIdx, base + 2);
    chk(busy == 1'b0, "R10 idle after", busy, 0);
    chk(overrun == 1'b1, "R10 overrun sticky", overrun, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSingle();
    testFields();
    testPending();
    testOverrun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule